// File: doc/BRIEF.md
# Power-On Register Script Sequencer

This block brings a set of configuration registers to their start-up values. Once reset is released it reads a stored script, one entry at a time, and turns each entry into a single write on the internal register bus. Each entry pairs a register number with a 16-bit value. The writes go out in the same order as the entries appear in the script.

An array register, for example a 256-entry window table living at register 25, is filled by placing many entries with that same register number one after another. Each of these entries produces its own write. The script ends at the first entry whose register number is the end marker 0xFF, or when the last slot of the script memory has been used, whichever comes first.

While the replay runs, the block holds off host register writes. Afterwards it forwards them to the same bus. Editing the script memory after start-up has no effect on live registers, because the script is only replayed after the next reset.

Top module: `cfg_init_seq`

## Requirements
- R1: While reset is high, busy is 1, done is 0 and reg_wr is 0.
- R2: After reset release the entries are applied in index order, one reg_wr pulse per entry. Entry bits [23:16] form reg_addr and bits [15:0] form reg_data.
- R3: Consecutive entries that carry the same register number each produce their own write with their own value, so an array register is loaded by repetition.
- R4: An entry whose register number field is 0xFF ends the script. That entry is not written, and done rises afterwards.
- R5: If all DEPTH entries are used without an end marker, exactly DEPTH writes are issued and done then rises.
- R6: Script reads have one cycle of latency. scr_rd and the sequencer's reg_wr are each never high in two consecutive cycles while busy.
- R7: Once done is high it stays high, busy stays low, and no further script reads occur until reset.
- R8: Host writes presented while busy is high never reach the register bus.
- R9: Once done is high, a host write is forwarded as reg_wr with the host address and data in the following cycle.
- R10: Changing the script memory after done causes no register writes. The next reset replays the changed script.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scr_rd | output | 1 | Script memory read enable |
| scr_addr | output | 6 | Script entry index |
| scr_entry | input | 24 | Entry read back one cycle after scr_rd: register number [23:16], value [15:0] |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register number |
| host_data | input | 16 | Host write value |
| reg_wr | output | 1 | Register bus write strobe |
| reg_addr | output | 8 | Register bus register number |
| reg_data | output | 16 | Register bus value |
| busy | output | 1 | Script replay in progress |
| done | output | 1 | Script replay finished |

## Verification
The assertions assume that reset is held for at least one clock and that the script memory returns its data exactly one cycle after a read request. The bench meets this by using a registered memory model that only updates on scr_rd. Host strobes are changed on the falling edge, based on the busy level seen there, so during the replay any host write lands in a sequencer state and never in a hand-over cycle that the checks have not accounted for. Script contents are random except for the end marker, which is placed only where a test intends it.

// File: rtl/cfg_init_seq.sv
module cfg_init_seq #(
  parameter int RA_W  = 8,
  parameter int VAL_W = 16,
  parameter int DEPTH = 64,
  parameter logic [RA_W-1:0] END_REG = '1
) (
  input  logic                               clk,
  input  logic                               rst,
  output logic                               scr_rd,
  output logic [(DEPTH>1?$clog2(DEPTH):1)-1:0] scr_addr,
  input  logic [RA_W+VAL_W-1:0]              scr_entry,
  input  logic                               host_wr,
  input  logic [RA_W-1:0]                    host_addr,
  input  logic [VAL_W-1:0]                   host_data,
  output logic                               reg_wr,
  output logic [RA_W-1:0]                    reg_addr,
  output logic [VAL_W-1:0]                   reg_data,
  output logic                               busy,
  output logic                               done
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  typedef enum logic [1:0] {S_FETCH, S_EVAL, S_DONE} st_t;

  st_t              st;
  logic [IDX_W-1:0] idx;
  logic [RA_W-1:0]  ent_reg;
  logic [VAL_W-1:0] ent_val;

  assign ent_reg  = scr_entry[RA_W+VAL_W-1:VAL_W];
  assign ent_val  = scr_entry[VAL_W-1:0];
  assign scr_rd   = (st == S_FETCH) && !rst;
  assign scr_addr = idx;
  assign busy     = (st != S_DONE);
  assign done     = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_FETCH;
      idx      <= '0;
      reg_wr   <= 1'b0;
      reg_addr <= '0;
      reg_data <= '0;
    end else begin
      reg_wr <= 1'b0;
      case (st)
        S_FETCH: st <= S_EVAL;
        S_EVAL: begin
          if (ent_reg == END_REG) begin
            st <= S_DONE;
          end else begin
            reg_wr   <= 1'b1;
            reg_addr <= ent_reg;
            reg_data <= ent_val;
            if (idx == LAST) begin
              st <= S_DONE;
            end else begin
              idx <= idx + 1'b1;
              st  <= S_FETCH;
            end
          end
        end
        S_DONE: begin
          if (host_wr) begin
            reg_wr   <= 1'b1;
            reg_addr <= host_addr;
            reg_data <= host_data;
          end
        end
        default: st <= S_DONE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_init_seq_chk.sv
module cfg_init_seq_chk (
  input logic clk,
  input logic rst,
  input logic scr_rd,
  input logic reg_wr,
  input logic busy,
  input logic done
);
  assert_strobe_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr) |=> !reg_wr);

  assert_read_gap_R6: assert property (@(posedge clk) disable iff (rst)
    scr_rd |=> !scr_rd);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !busy));

  assert_no_read_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !scr_rd);
endmodule

bind cfg_init_seq cfg_init_seq_chk u_chk (
  .clk(clk), .rst(rst), .scr_rd(scr_rd), .reg_wr(reg_wr), .busy(busy), .done(done)
);

// File: tb/sim_cfg_init_seq.sv
`timescale 1ns/1ps
module sim_cfg_init_seq;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scr_rd;
  logic [5:0]  scr_addr;
  logic [23:0] scr_q = '0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [15:0] host_data = '0;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [15:0] reg_data;
  logic        busy, done;

  logic [23:0] mem [DEPTH];
  logic [7:0]  log_a [128];
  logic [15:0] log_d [128];
  int n_log = 0;
  int errors = 0, checks = 0;
  int gap_err = 0, rd_after_done = 0;
  int cycles = 0;
  bit prev_swr = 0, prev_rd = 0;

  always #2.5 clk = ~clk;

  cfg_init_seq u0 (
    .clk(clk), .rst(rst), .scr_rd(scr_rd), .scr_addr(scr_addr), .scr_entry(scr_q),
    .host_wr(host_wr), .host_addr(host_addr), .host_data(host_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data),
    .busy(busy), .done(done)
  );

  always @(posedge clk) if (scr_rd) scr_q <= mem[scr_addr];

  always @(negedge clk) begin
    if (!rst) begin
      if (reg_wr && n_log < 128) begin
        log_a[n_log] = reg_addr;
        log_d[n_log] = reg_data;
        n_log++;
      end
      if (reg_wr && busy && prev_swr) gap_err++;
      if (scr_rd && prev_rd) gap_err++;
      if (scr_rd && done) rd_after_done++;
      prev_swr = reg_wr && busy;
      prev_rd  = scr_rd;
    end else begin
      prev_swr = 0;
      prev_rd  = 0;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len();
    for (int i = 0; i < DEPTH; i++)
      if (mem[i][23:16] == 8'hFF) return i;
    return DEPTH;
  endfunction

  task automatic fill_random(input int len);
    for (int i = 0; i < DEPTH; i++) begin
      mem[i][23:16] = 8'($urandom % 255);
      mem[i][15:0]  = 16'($urandom);
    end
    if (len < DEPTH) mem[len][23:16] = 8'hFF;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    host_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R1 busy in reset", busy, 1);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(reg_wr == 1'b0, "R1 reg_wr in reset", reg_wr, 0);
    n_log = 0;
    gap_err = 0;
    rd_after_done = 0;
    rst = 1'b0;
  endtask

  task automatic replay(input string tag, input bit poke_host);
    int len, t;
    len = exp_len();
    do_reset();
    t = 0;
    while (!done && t < 1000) begin
      if (poke_host) begin
        host_wr   = 1'b1;
        host_addr = 8'($urandom);
        host_data = 16'($urandom);
      end
      @(negedge clk);
      t++;
    end
    host_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk(done == 1'b1, {tag, " R4/R5 done reached"}, done, 1);
    chk(n_log == len, {tag, " R2/R8 write count"}, n_log, len);
    for (int i = 0; i < len && i < n_log; i++) begin
      chk(log_a[i] == mem[i][23:16], {tag, " R2/R3 reg_addr order"}, log_a[i], mem[i][23:16]);
      chk(log_d[i] == mem[i][15:0], {tag, " R2/R3 reg_data order"}, log_d[i], mem[i][15:0]);
    end
    chk(gap_err == 0, {tag, " R6 strobe spacing"}, gap_err, 0);
    chk(rd_after_done == 0 && busy == 1'b0, {tag, " R7 idle after done"}, rd_after_done, 0);
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'h5EED);

    // R4: end marker at entry 0, nothing written
    fill_random(0);
    replay("empty", 1'b1);

    // R3: window-table style array at register 25
    fill_random(20);
    for (int i = 0; i < 12; i++) mem[i] = {8'd25, 16'(i * 16'h0101 + 3)};
    mem[12] = {8'd23, 16'h0100};
    replay("array", 1'b1);

    // R5: full depth without an end marker
    fill_random(DEPTH);
    replay("full", 1'b0);

    // R9: host write forwarded after done
    @(negedge clk);
    n_log = 0;
    host_wr = 1'b1; host_addr = 8'd24; host_data = 16'h302A;
    @(negedge clk);
    host_wr = 1'b0;
    chk(reg_wr == 1'b1, "R9 host strobe forwarded", reg_wr, 1);
    chk(reg_addr == 8'd24, "R9 host address forwarded", reg_addr, 24);
    chk(reg_data == 16'h302A, "R9 host data forwarded", reg_data, 16'h302A);

    // R10: editing script after done has no effect until reset
    fill_random(5);
    repeat (2) @(negedge clk);
    n_log = 0;
    repeat (30) @(negedge clk);
    chk(n_log == 0, "R10 no writes after script edit", n_log, 0);
    replay("rerun", 1'b0);

    // R2/R8: random scripts with host writes during replay
    for (int r = 0; r < 6; r++) begin
      fill_random(1 + ($urandom % (DEPTH - 1)));
      replay("rand", 1'b1);
    end

    summary();
  end
endmodule